// File: doc/BRIEF.md
# NOR Flash Bus Cycle Timer

This block turns one request from a command sequencer into the pin waveform of one asynchronous NOR flash bus cycle. A request is a read or write flag, an address and, for a write, a data word. The block drives chip enable, output enable, write enable and the address bus. It drives the 16-bit data bus through a split output, output-enable and input port set, which the pad ring joins into one bidirectional pin group. A read captures the data bus and returns the word together with a one-clock done pulse. A write returns only the done pulse.

Every interval in the waveform is a parameter given in system clocks. These are the address setup before the write strobe falls, the write strobe low time (address hold), the data hold after the strobe rises, the strobe-high recovery before the next cycle, and the read access time. This lets one netlist be tuned to the device that is fitted. A parameter set to zero still gives one clock.

The controller has seven named states. ST_IDLE waits for a request. ST_WR_SETUP counts address and data setup. ST_WR_PULSE holds write enable low. ST_WR_HOLD keeps the data driven after write enable rises. ST_WR_RECOVER returns all strobes high. ST_RD_ACCESS holds chip enable and output enable low for the access time. ST_DONE issues the done pulse. The transitions are: idle to write-setup or read-access on an accepted request; write-setup to pulse, pulse to hold, hold to recover, and recover to done, each when its interval counter expires; read-access to done when its counter expires, with the bus captured on that edge; and done to idle unconditionally.

Top module: `nor_bus_timer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, all three strobes are high, the data output enable is 0, done is 0, idle is 1 and the address bus is 0.
- R2: A write accepted on edge k drives the request address on the address bus and the write word on the data bus, with data output enable 1, from edge k. Chip enable is low and write and output enables are high for max(1,T_AS) clocks.
- R3: Write enable is then low for max(1,T_AH) clocks, with chip enable low, output enable high, and the address and data unchanged.
- R4: After write enable rises, chip enable stays low and the data stays driven for max(1,T_DH) clocks.
- R5: Then all strobes are high and the data output enable is 0 for max(1,T_WPH) clocks before done.
- R6: A read accepted on edge k holds chip enable and output enable low and write enable high for max(1,T_AA) clocks from edge k. The data output enable stays 0.
- R7: The read word is the value of the data input at the edge that ends the access interval. It appears on rdata in the same cycle as done, and rdata keeps it until the next read ends.
- R8: Done is high for exactly one clock after each cycle, with all strobes high. Idle is 1 on the next cycle.
- R9: A request is accepted only on an edge where idle is 1. Requests raised while busy do not change the address, the data or the waveform.
- R10: While idle, the address bus and the data output value keep their last values whatever the request inputs do.
- R11: An interval parameter of zero behaves as one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| req_valid | input | 1 | Request present; taken when idle is 1 |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | AW | Flash address of the request |
| req_wdata | input | DW | Word to write |
| idle | output | 1 | Block can accept a request this cycle |
| done | output | 1 | One-clock end-of-cycle pulse |
| rdata | output | DW | Word captured by the last read |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_oe_n | output | 1 | Output enable, active low |
| flash_we_n | output | 1 | Write enable, active low |
| flash_addr | output | AW | Flash address bus |
| flash_dq_o | output | DW | Data bus output value |
| flash_dq_oe | output | 1 | Data bus output enable, 1 drives the bus |
| flash_dq_i | input | DW | Data bus input value |

## Verification
The bench instantiates the block with a zero data-hold parameter and unequal other intervals. A design that ignored the minimum of one clock would skip the hold phase and release data while write enable rises. A design that swapped intervals would leave a phase the wrong length. The data input changes every clock, so capturing one edge early or late returns a neighbouring word. Requests held high across done, and requests raised while busy, test that acceptance happens only in idle. A busy-time accept would move the address under a low write strobe. Idle periods with changing request inputs show whether the address bus keeps its last value.

// File: rtl/nbt_pkg.sv
package nbt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_WR_RECOVER,
        ST_RD_ACCESS,
        ST_DONE
    } nbt_state_e;

    // Returns an interval length of at least one clock.
    function automatic int unsigned nbt_clamp(input int unsigned v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int unsigned nbt_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/nbt_interval_cnt.sv
module nbt_interval_cnt #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/nbt_pin_drive.sv
module nbt_pin_drive
    import nbt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  nbt_state_e state_nx,
    output logic       ce_n,
    output logic       oe_n,
    output logic       we_n,
    output logic       dq_oe,
    output logic       done
);
    logic ce_d, oe_d, we_d, dq_d, done_d;

    // Pin levels for the state being entered, registered so the pins are glitch free.
    always_comb begin
        ce_d   = 1'b1;
        oe_d   = 1'b1;
        we_d   = 1'b1;
        dq_d   = 1'b0;
        done_d = 1'b0;
        unique case (state_nx)
            ST_IDLE: ;
            ST_WR_SETUP: begin
                ce_d = 1'b0;
                dq_d = 1'b1;
            end
            ST_WR_PULSE: begin
                ce_d = 1'b0;
                we_d = 1'b0;
                dq_d = 1'b1;
            end
            ST_WR_HOLD: begin
                ce_d = 1'b0;
                dq_d = 1'b1;
            end
            ST_WR_RECOVER: ;
            ST_RD_ACCESS: begin
                ce_d = 1'b0;
                oe_d = 1'b0;
            end
            ST_DONE: done_d = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            ce_n  <= 1'b1;
            oe_n  <= 1'b1;
            we_n  <= 1'b1;
            dq_oe <= 1'b0;
            done  <= 1'b0;
        end else begin
            ce_n  <= ce_d;
            oe_n  <= oe_d;
            we_n  <= we_d;
            dq_oe <= dq_d;
            done  <= done_d;
        end
    end
endmodule

// File: rtl/nor_bus_timer.sv
module nor_bus_timer
    import nbt_pkg::*;
#(
    parameter int unsigned AW    = 16,
    parameter int unsigned DW    = 16,
    parameter int unsigned T_AS  = 2,
    parameter int unsigned T_AH  = 3,
    parameter int unsigned T_DH  = 1,
    parameter int unsigned T_WPH = 2,
    parameter int unsigned T_AA  = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          idle,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic          flash_ce_n,
    output logic          flash_oe_n,
    output logic          flash_we_n,
    output logic [AW-1:0] flash_addr,
    output logic [DW-1:0] flash_dq_o,
    output logic          flash_dq_oe,
    input  logic [DW-1:0] flash_dq_i
);
    localparam int unsigned N_AS  = nbt_clamp(T_AS);
    localparam int unsigned N_AH  = nbt_clamp(T_AH);
    localparam int unsigned N_DH  = nbt_clamp(T_DH);
    localparam int unsigned N_WPH = nbt_clamp(T_WPH);
    localparam int unsigned N_AA  = nbt_clamp(T_AA);
    localparam int unsigned N_MAX = nbt_max(nbt_max(nbt_max(N_AS, N_AH), nbt_max(N_DH, N_WPH)), N_AA);
    localparam int unsigned CW    = (N_MAX > 1) ? $clog2(N_MAX) : 1;

    nbt_state_e    state_q, state_nx;
    logic          cnt_load;
    logic [CW-1:0] cnt_val;
    logic          cnt_expired;
    logic          accept;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rdata_q;

    assign accept = (state_q == ST_IDLE) && req_valid;

    // State register.
    always_ff @(posedge clk or posedge rst) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_nx;
    end

    // Next state and interval loading.
    always_comb begin
        state_nx = state_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    cnt_load = 1'b1;
                    if (req_write) begin
                        state_nx = ST_WR_SETUP;
                        cnt_val  = CW'(N_AS - 1);
                    end else begin
                        state_nx = ST_RD_ACCESS;
                        cnt_val  = CW'(N_AA - 1);
                    end
                end
            end
            ST_WR_SETUP: begin
                if (cnt_expired) begin
                    state_nx = ST_WR_PULSE;
                    cnt_load = 1'b1;
                    cnt_val  = CW'(N_AH - 1);
                end
            end
            ST_WR_PULSE: begin
                if (cnt_expired) begin
                    state_nx = ST_WR_HOLD;
                    cnt_load = 1'b1;
                    cnt_val  = CW'(N_DH - 1);
                end
            end
            ST_WR_HOLD: begin
                if (cnt_expired) begin
                    state_nx = ST_WR_RECOVER;
                    cnt_load = 1'b1;
                    cnt_val  = CW'(N_WPH - 1);
                end
            end
            ST_WR_RECOVER: begin
                if (cnt_expired) state_nx = ST_DONE;
            end
            ST_RD_ACCESS: begin
                if (cnt_expired) state_nx = ST_DONE;
            end
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    nbt_interval_cnt #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (cnt_val),
        .expired  (cnt_expired)
    );

    nbt_pin_drive u_pins (
        .clk      (clk),
        .rst      (rst),
        .state_nx (state_nx),
        .ce_n     (flash_ce_n),
        .oe_n     (flash_oe_n),
        .we_n     (flash_we_n),
        .dq_oe    (flash_dq_oe),
        .done     (done)
    );

    // Request latch and read capture.
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if ((state_q == ST_RD_ACCESS) && cnt_expired) begin
                rdata_q <= flash_dq_i;
            end
        end
    end

    assign idle       = (state_q == ST_IDLE);
    assign flash_addr = addr_q;
    assign flash_dq_o = wdata_q;
    assign rdata      = rdata_q;
endmodule

// File: rtl/nbt_checker.sv
module nbt_checker #(
    parameter int unsigned AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          idle,
    input logic          done,
    input logic          ce_n,
    input logic          oe_n,
    input logic          we_n,
    input logic          dq_oe,
    input logic [AW-1:0] addr
);
    p_no_bus_fight_r6: assert property (@(posedge clk) disable iff (rst)
        !(!we_n && !oe_n));

    p_we_inside_ce_r3: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> !ce_n);

    p_drive_only_write_r6: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> (!ce_n && oe_n));

    p_addr_stable_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> $stable(addr));

    p_data_held_at_rise_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(we_n) |-> dq_oe);

    p_done_strobes_high_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> (ce_n && oe_n && we_n && !dq_oe));

    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && idle));

    p_addr_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (idle && $past(idle)) |-> $stable(addr));
endmodule

bind nor_bus_timer nbt_checker #(.AW(AW)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .idle  (idle),
    .done  (done),
    .ce_n  (flash_ce_n),
    .oe_n  (flash_oe_n),
    .we_n  (flash_we_n),
    .dq_oe (flash_dq_oe),
    .addr  (flash_addr)
);

// File: tb/sim_nor_bus_timer.sv
`timescale 1ns/1ps
module sim_nor_bus_timer;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int P_AS = 2, P_AH = 3, P_DH = 0, P_WPH = 2, P_AA = 4;

    function automatic int atleast1(input int v);
        return (v < 1) ? 1 : v;
    endfunction

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic idle, done, ce_n, oe_n, we_n, dq_oe;
    logic [DW-1:0] rdata, dq_o;
    logic [DW-1:0] dq_i = '0;
    logic [AW-1:0] addr;

    always #2.5 clk = ~clk;

    nor_bus_timer #(.AW(AW), .DW(DW), .T_AS(P_AS), .T_AH(P_AH), .T_DH(P_DH),
                    .T_WPH(P_WPH), .T_AA(P_AA)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .idle(idle), .done(done),
        .rdata(rdata), .flash_ce_n(ce_n), .flash_oe_n(oe_n), .flash_we_n(we_n),
        .flash_addr(addr), .flash_dq_o(dq_o), .flash_dq_oe(dq_oe), .flash_dq_i(dq_i)
    );

    typedef struct packed {
        logic ce, oe, we, dqoe, dn, idl, cap;
        logic [2:0] ph;
    } ent_t;

    ent_t ent_q[$];
    ent_t cur;
    logic [AW-1:0] addr_exp = '0;
    logic [DW-1:0] wdata_exp = '0;
    logic [DW-1:0] rdata_exp = '0;
    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit model_on = 0;

    localparam ent_t E_IDLE = '{ce:1, oe:1, we:1, dqoe:0, dn:0, idl:1, cap:0, ph:3'd1};

    function automatic string tag_of(input logic [2:0] ph);
        case (ph)
            3'd2: return "R2";
            3'd3: return "R3";
            3'd4: return "R4 R11";
            3'd5: return "R5";
            3'd6: return "R6";
            3'd7: return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic push_n(input int n, input ent_t e);
        for (int i = 0; i < n; i++) ent_q.push_back(e);
    endtask

    // Behavioural reference: expected pins per cycle.
    always @(posedge clk) begin
        if (rst || !model_on) begin
            cur = E_IDLE;
            ent_q.delete();
        end else begin
            if (cur.idl && req_valid) begin
                addr_exp  = req_addr;
                wdata_exp = req_wdata;
                if (req_write) begin
                    push_n(atleast1(P_AS),  '{ce:0, oe:1, we:1, dqoe:1, dn:0, idl:0, cap:0, ph:3'd2});
                    push_n(atleast1(P_AH),  '{ce:0, oe:1, we:0, dqoe:1, dn:0, idl:0, cap:0, ph:3'd3});
                    push_n(atleast1(P_DH),  '{ce:0, oe:1, we:1, dqoe:1, dn:0, idl:0, cap:0, ph:3'd4});
                    push_n(atleast1(P_WPH), '{ce:1, oe:1, we:1, dqoe:0, dn:0, idl:0, cap:0, ph:3'd5});
                    push_n(1,               '{ce:1, oe:1, we:1, dqoe:0, dn:1, idl:0, cap:0, ph:3'd7});
                end else begin
                    push_n(atleast1(P_AA),  '{ce:0, oe:0, we:1, dqoe:0, dn:0, idl:0, cap:0, ph:3'd6});
                    push_n(1,               '{ce:1, oe:1, we:1, dqoe:0, dn:1, idl:0, cap:1, ph:3'd7});
                end
            end
            if (ent_q.size() > 0) cur = ent_q.pop_front();
            else cur = E_IDLE;
            if (cur.cap) rdata_exp = dq_i;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // Compare every cycle away from the active edge.
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (!rst && model_on) begin
                chk(tag_of(cur.ph), "strobes ce/oe/we/dq_oe",
                    {28'd0, ce_n, oe_n, we_n, dq_oe}, {28'd0, cur.ce, cur.oe, cur.we, cur.dqoe});
                chk("R8", "done", {31'd0, done}, {31'd0, cur.dn});
                chk("R9", "idle", {31'd0, idle}, {31'd0, cur.idl});
                chk("R10", "addr", {16'd0, addr}, {16'd0, addr_exp});
                chk("R7", "rdata", {16'd0, rdata}, {16'd0, rdata_exp});
                if (cur.dqoe) chk("R2", "write data", {16'd0, dq_o}, {16'd0, wdata_exp});
                if (!cur.dqoe && cur.idl) chk("R10", "idle data value", {16'd0, dq_o}, {16'd0, wdata_exp});
            end
        end
    end

    // Data input changes every clock so capture timing is visible.
    initial begin
        forever begin
            @(negedge clk);
            dq_i = 16'hA000 + 16'(cyc * 7);
        end
    end

    task automatic issue(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        while (!idle) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (!done) @(negedge clk);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        int wd = 0;
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 50000) begin
                tests++; fails++;
                $display("FAIL watchdog: actual running expected finished");
                summary();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "reset strobes", {29'd0, ce_n, oe_n, we_n}, 32'd7);
        chk("R1", "reset dq_oe/done", {30'd0, dq_oe, done}, 32'd0);
        chk("R1", "reset idle", {31'd0, idle}, 32'd1);
        chk("R1", "reset addr", {16'd0, addr}, 32'd0);
        rst = 1'b0;
        model_on = 1;
        @(negedge clk);
        chk("R1", "first cycle strobes", {29'd0, ce_n, oe_n, we_n}, 32'd7);

        // R2 R3 R4 R5 R11: single write
        issue(1'b1, 16'h1234, 16'hBEEF);
        wait_done();
        // R6 R7: single read
        issue(1'b0, 16'h0042, 16'h0000);
        wait_done();
        // R10: idle with changing request inputs
        req_addr = 16'hFFFF; req_wdata = 16'h5555;
        repeat (5) @(negedge clk);
        chk("R10", "addr held idle", {16'd0, addr}, 32'h0042);

        // R9: requests while busy are ignored
        issue(1'b1, 16'h0A0A, 16'h1111);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h7777;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        wait_done();
        chk("R9", "addr after busy request", {16'd0, addr}, 32'h0A0A);

        // R9 R8: request held across done, back to back writes
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0100; req_wdata = 16'hC0DE;
        wait_done();
        req_addr = 16'h0200; req_wdata = 16'hF00D;
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        wait_done();
        chk("R9", "second back-to-back addr", {16'd0, addr}, 32'h0200);

        // R7: rdata kept across a write, then new read
        chk("R7", "rdata after writes", {16'd0, rdata}, {16'd0, rdata_exp});
        issue(1'b0, 16'h0333, 16'h0000);
        wait_done();
        issue(1'b0, 16'h0334, 16'h0000);
        wait_done();
        repeat (4) @(negedge clk);
        summary();
    end
endmodule